// File: doc/BRIEF.md
# USB Source Classification Sequencer

This block works out what kind of USB power source is attached and chooses an input current limit for the charger from that result. Once power-good is seen, it first checks whether the data lines have made contact. It does this by enabling a current source on D+ and a pull-down on D– and waiting for D+ to fall. When contact is seen, it runs a timed primary check. This check enables a voltage source on D+ and a current sink on D–, and at the end it reads D– to tell a standard host port from a charging port. When contact never arrives, it decodes the bias that a resistor divider in a non-standard adapter places on the lines.

All timing comes from a millisecond tick input. The analog comparators are outside the block and deliver logic levels and window flags. The block drives the four line-driver enables and reports a 2-bit port type, a 3-bit limit code and a done flag. The result stays in place until software requests a new detection or power-good drops.

Top module: `usb_src_classifier`

## Requirements
- R1: After reset, and while power-good stays low, all four line-driver enables are 0, det_done is 0, port_type is 00 and ilim_code is 1. One cycle after power-good is seen high in idle, the D+ current source and the D– pull-down are enabled.
- R2: In the contact phase, a D+ level that was high in one cycle and low in the next ends the phase. From the next cycle the D+ current source and D– pull-down are off, and the D+ voltage source and D– current sink are on.
- R3: If CONTACT_MS ticks (default 500) arrive in the contact phase without contact, all line drivers are switched off in the next cycle. The adapter classification follows, and det_done rises one cycle after that.
- R4: The primary phase lasts PRIMARY_MS ticks (default 40). On the last tick D– is sampled. D– low gives port_type 01, with ilim_code 0 (100 mA) when the OTG pin is low and 1 (500 mA) when it is high. ilim_code encoding: 0=100 mA, 1=500 mA, 2=1 A, 3=2 A, 4=3 A.
- R5: D– high at the end of the primary phase gives port_type 10 and ilim_code 4 (3 A).
- R6: The adapter classification checks three patterns in a fixed order, and the first match wins. First, D+ inside the upper window with D– outside it gives code 3. Second, D+ inside the lower window gives code 3. Third, D+ outside the upper window with D– inside it gives code 2. Any match reports port_type 10.
- R7: If no adapter pattern matches, port_type is 00 and ilim_code is 1 (500 mA).
- R8: While det_done is 1, port_type and ilim_code hold. A one-cycle redetect_req in the done state clears det_done and re-enables the contact drivers in the next cycle. The previous result stays on the outputs until the new one is ready.
- R9: A redetect_req that arrives while a detection is running has no effect, and the running phase completes on its normal schedule.
- R10: Power-good low in any state returns the block to idle by the next cycle. All drivers go off, det_done clears, port_type becomes 00 and ilim_code becomes 1.
- R11: The contact driver pair and the primary driver pair are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_good | input | 1 | Bus supply present and good |
| dp_high | input | 1 | D+ logic level |
| dm_high | input | 1 | D– logic level |
| dp_in_upper | input | 1 | D+ inside the upper divider window |
| dp_in_lower | input | 1 | D+ inside the lower divider window |
| dm_in_upper | input | 1 | D– inside the upper divider window |
| otg_level | input | 1 | OTG pin level |
| redetect_req | input | 1 | One-cycle request to repeat detection |
| dp_isrc_en | output | 1 | D+ current source enable |
| dm_pulldn_en | output | 1 | D– pull-down enable |
| dp_vsrc_en | output | 1 | D+ voltage source enable |
| dm_isink_en | output | 1 | D– current sink enable |
| port_type | output | 2 | 00 unknown, 01 host port, 10 charging/adapter port |
| ilim_code | output | 3 | Input current limit code |
| det_done | output | 1 | Detection complete, result valid |

## Verification
A wrong sequencer state shows at the driver enables within one cycle, because each phase owns a distinct enable pattern. A phase that runs too long or too short shifts the cycle in which the enables switch and det_done rises. The bench samples this on the exact tick boundary, one tick early and at the boundary itself. A wrong classification shows as a port_type or ilim_code mismatch in the cycle det_done rises, and the outputs are then checked for holding until the next request.

// File: rtl/usb_src_pkg.sv
package usb_src_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONTACT,
        ST_PRIMARY,
        ST_ADAPTER,
        ST_DONE
    } det_state_e;

    localparam logic [2:0] ILIM_100MA = 3'd0;
    localparam logic [2:0] ILIM_500MA = 3'd1;
    localparam logic [2:0] ILIM_1A    = 3'd2;
    localparam logic [2:0] ILIM_2A    = 3'd3;
    localparam logic [2:0] ILIM_3A    = 3'd4;

    localparam logic [1:0] PT_UNKNOWN = 2'b00;
    localparam logic [1:0] PT_HOST    = 2'b01;
    localparam logic [1:0] PT_CHARGER = 2'b10;

endpackage

// File: rtl/det_tick_timer.sv
module det_tick_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (run && tick)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign hit = run && tick && (count_q == limit - 1'b1);
endmodule

// File: rtl/det_adapter_decode.sv
module det_adapter_decode
    import usb_src_pkg::*;
(
    input  logic       dp_in_upper,
    input  logic       dp_in_lower,
    input  logic       dm_in_upper,
    output logic       match,
    output logic [2:0] code
);
    always_comb begin
        match = 1'b1;
        code  = ILIM_500MA;
        if (dp_in_upper && !dm_in_upper)
            code = ILIM_2A;
        else if (dp_in_lower)
            code = ILIM_2A;
        else if (!dp_in_upper && dm_in_upper)
            code = ILIM_1A;
        else
            match = 1'b0;
    end
endmodule

// File: rtl/det_drive_map.sv
module det_drive_map
    import usb_src_pkg::*;
(
    input  det_state_e st,
    output logic       dp_isrc_en,
    output logic       dm_pulldn_en,
    output logic       dp_vsrc_en,
    output logic       dm_isink_en
);
    always_comb begin
        dp_isrc_en   = (st == ST_CONTACT);
        dm_pulldn_en = (st == ST_CONTACT);
        dp_vsrc_en   = (st == ST_PRIMARY);
        dm_isink_en  = (st == ST_PRIMARY);
    end
endmodule

// File: rtl/usb_src_classifier.sv
module usb_src_classifier
    import usb_src_pkg::*;
#(
    parameter int CONTACT_MS = 500,
    parameter int PRIMARY_MS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       pwr_good,
    input  logic       dp_high,
    input  logic       dm_high,
    input  logic       dp_in_upper,
    input  logic       dp_in_lower,
    input  logic       dm_in_upper,
    input  logic       otg_level,
    input  logic       redetect_req,
    output logic       dp_isrc_en,
    output logic       dm_pulldn_en,
    output logic       dp_vsrc_en,
    output logic       dm_isink_en,
    output logic [1:0] port_type,
    output logic [2:0] ilim_code,
    output logic       det_done
);
    localparam int MAX_MS = (CONTACT_MS > PRIMARY_MS) ? CONTACT_MS : PRIMARY_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    typedef struct packed {
        det_state_e  state;
        logic        dp_prev;
        logic [1:0]  ptype;
        logic [2:0]  ilim;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic          t_hit, t_run, t_clr;
    logic [TW-1:0] t_limit;
    logic          ad_match;
    logic [2:0]    ad_code;

    assign t_run   = (cur_q.state == ST_CONTACT) || (cur_q.state == ST_PRIMARY);
    assign t_limit = (cur_q.state == ST_CONTACT) ? TW'(CONTACT_MS) : TW'(PRIMARY_MS);
    assign t_clr   = (nxt_d.state != cur_q.state);

    det_tick_timer #(.W(TW)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .run   (t_run),
        .tick  (ms_tick),
        .limit (t_limit),
        .hit   (t_hit)
    );

    det_adapter_decode i_decode (
        .dp_in_upper (dp_in_upper),
        .dp_in_lower (dp_in_lower),
        .dm_in_upper (dm_in_upper),
        .match       (ad_match),
        .code        (ad_code)
    );

    det_drive_map i_drive (
        .st           (cur_q.state),
        .dp_isrc_en   (dp_isrc_en),
        .dm_pulldn_en (dm_pulldn_en),
        .dp_vsrc_en   (dp_vsrc_en),
        .dm_isink_en  (dm_isink_en)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                nxt_d.dp_prev = 1'b0;
                if (pwr_good)
                    nxt_d.state = ST_CONTACT;
            end
            ST_CONTACT: begin
                nxt_d.dp_prev = dp_high;
                if (cur_q.dp_prev && !dp_high)
                    nxt_d.state = ST_PRIMARY;
                else if (t_hit)
                    nxt_d.state = ST_ADAPTER;
            end
            ST_PRIMARY: begin
                if (t_hit) begin
                    nxt_d.state = ST_DONE;
                    if (dm_high) begin
                        nxt_d.ptype = PT_CHARGER;
                        nxt_d.ilim  = ILIM_3A;
                    end else begin
                        nxt_d.ptype = PT_HOST;
                        nxt_d.ilim  = otg_level ? ILIM_500MA : ILIM_100MA;
                    end
                end
            end
            ST_ADAPTER: begin
                nxt_d.state = ST_DONE;
                nxt_d.ptype = ad_match ? PT_CHARGER : PT_UNKNOWN;
                nxt_d.ilim  = ad_match ? ad_code : ILIM_500MA;
            end
            ST_DONE: begin
                if (redetect_req) begin
                    nxt_d.state   = ST_CONTACT;
                    nxt_d.dp_prev = 1'b0;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        if (!pwr_good) begin
            nxt_d.state   = ST_IDLE;
            nxt_d.dp_prev = 1'b0;
            nxt_d.ptype   = PT_UNKNOWN;
            nxt_d.ilim    = ILIM_500MA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= ST_IDLE;
            cur_q.dp_prev <= 1'b0;
            cur_q.ptype   <= PT_UNKNOWN;
            cur_q.ilim    <= ILIM_500MA;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign port_type = cur_q.ptype;
    assign ilim_code = cur_q.ilim;
    assign det_done  = (cur_q.state == ST_DONE);
endmodule

// File: rtl/usb_src_classifier_chk.sv
module usb_src_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       redetect_req,
    input logic       dp_isrc_en,
    input logic       dm_pulldn_en,
    input logic       dp_vsrc_en,
    input logic       dm_isink_en,
    input logic [1:0] port_type,
    input logic [2:0] ilim_code,
    input logic       det_done
);
    AST_PAIRS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((dp_isrc_en || dm_pulldn_en) && (dp_vsrc_en || dm_isink_en))); // R11

    AST_PG_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!det_done && !dp_isrc_en && !dm_pulldn_en && !dp_vsrc_en
                       && !dm_isink_en && port_type == 2'b00 && ilim_code == 3'd1)); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && $past(det_done)) |-> ($stable(port_type) && $stable(ilim_code))); // R8

    AST_REDETECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && redetect_req && pwr_good) |=> (!det_done && dp_isrc_en && dm_pulldn_en)); // R8

    AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (port_type != 2'b11) && (ilim_code <= 3'd4)); // R6

    AST_HOST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && port_type == 2'b01) |-> (ilim_code <= 3'd1)); // R4

    AST_CONTACT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dp_isrc_en == dm_pulldn_en); // R2
endmodule

bind usb_src_classifier usb_src_classifier_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .redetect_req (redetect_req),
    .dp_isrc_en   (dp_isrc_en),
    .dm_pulldn_en (dm_pulldn_en),
    .dp_vsrc_en   (dp_vsrc_en),
    .dm_isink_en  (dm_isink_en),
    .port_type    (port_type),
    .ilim_code    (ilim_code),
    .det_done     (det_done)
);

// File: tb/test_usb_src_classifier.sv
module test_usb_src_classifier;
    localparam int CMS = 500;
    localparam int PMS = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, pwr_good = 1'b0, dp_high = 1'b0, dm_high = 1'b0;
    logic dp_in_upper = 1'b0, dp_in_lower = 1'b0, dm_in_upper = 1'b0;
    logic otg_level = 1'b0, redetect_req = 1'b0;
    logic dp_isrc_en, dm_pulldn_en, dp_vsrc_en, dm_isink_en, det_done;
    logic [1:0] port_type;
    logic [2:0] ilim_code;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    usb_src_classifier #(.CONTACT_MS(CMS), .PRIMARY_MS(PMS)) i_usb_src_classifier (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_good(pwr_good),
        .dp_high(dp_high), .dm_high(dm_high), .dp_in_upper(dp_in_upper),
        .dp_in_lower(dp_in_lower), .dm_in_upper(dm_in_upper), .otg_level(otg_level),
        .redetect_req(redetect_req), .dp_isrc_en(dp_isrc_en), .dm_pulldn_en(dm_pulldn_en),
        .dp_vsrc_en(dp_vsrc_en), .dm_isink_en(dm_isink_en), .port_type(port_type),
        .ilim_code(ilim_code), .det_done(det_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int drv_bits();
        return {dp_isrc_en, dm_pulldn_en, dp_vsrc_en, dm_isink_en};
    endfunction

    // expected {port_type, ilim_code} from the requirements
    function automatic int exp_primary(input bit dm, input bit otg);
        if (dm) return (2 << 3) | 4;
        return (1 << 3) | (otg ? 1 : 0);
    endfunction

    function automatic int exp_adapter(input bit up, input bit lo, input bit dmu);
        if (up && !dmu) return (2 << 3) | 3;
        if (lo)         return (2 << 3) | 3;
        if (!up && dmu) return (2 << 3) | 2;
        return 1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            step();
            ms_tick = 1'b0;
        end
    endtask

    task automatic contact_edge();
        dp_high = 1'b1;
        step();
        dp_high = 1'b0;
        step();
        chk("R2 drivers after contact", drv_bits(), 4'b0011);
    endtask

    task automatic run_primary(input bit dm, input bit otg, input bit poke);
        dm_high = dm;
        otg_level = otg;
        if (poke) begin
            tick(PMS / 2);
            redetect_req = 1'b1;
            step();
            redetect_req = 1'b0;
            chk("R9 redetect ignored mid-primary", drv_bits(), 4'b0011);
            tick(PMS / 2 - 1);
        end else begin
            tick(PMS - 1);
        end
        chk("R4 primary not yet done", det_done, 0);
        tick(1);
        chk("R4 done after primary", det_done, 1);
        chk(dm ? "R5 charger result" : "R4 host result",
            {port_type, ilim_code}, exp_primary(dm, otg));
    endtask

    task automatic run_timeout(input bit up, input bit lo, input bit dmu);
        int e;
        dp_high = 1'b0;
        dp_in_upper = up;
        dp_in_lower = lo;
        dm_in_upper = dmu;
        tick(CMS - 1);
        chk("R3 contact drivers before timeout", drv_bits(), 4'b1100);
        tick(1);
        chk("R3 drivers off after timeout", drv_bits(), 0);
        chk("R3 not done in classification", det_done, 0);
        step();
        chk("R3 done after classification", det_done, 1);
        e = exp_adapter(up, lo, dmu);
        chk((e == 1) ? "R7 no pattern result" : "R6 adapter result",
            {port_type, ilim_code}, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 reset drivers", drv_bits(), 0);
        chk("R1 reset done", det_done, 0);
        chk("R1 reset result", {port_type, ilim_code}, 1);
        redetect_req = 1'b1;
        step();
        redetect_req = 1'b0;
        chk("R1 redetect without power ignored", drv_bits(), 0);
        pwr_good = 1'b1;
        step();
        chk("R1 contact drivers on power-good", drv_bits(), 4'b1100);

        // directed: host, OTG low
        contact_edge();
        run_primary(1'b0, 1'b0, 1'b0);
        step();
        chk("R8 result held", {port_type, ilim_code}, exp_primary(0, 0));

        // directed: restart, redetect mid-run ignored, charger
        redetect_req = 1'b1;
        step();
        redetect_req = 1'b0;
        chk("R8 restart drivers", drv_bits(), 4'b1100);
        chk("R8 restart clears done", det_done, 0);
        chk("R8 old result held during rerun", {port_type, ilim_code}, exp_primary(0, 0));
        redetect_req = 1'b1;
        step();
        redetect_req = 1'b0;
        chk("R9 redetect ignored in contact", drv_bits(), 4'b1100);
        contact_edge();
        run_primary(1'b1, 1'b0, 1'b1);

        // directed adapter corners
        redetect_req = 1'b1; step(); redetect_req = 1'b0;
        run_timeout(1'b1, 1'b1, 1'b1);
        redetect_req = 1'b1; step(); redetect_req = 1'b0;
        run_timeout(1'b0, 1'b0, 1'b0);

        // power loss mid-primary
        redetect_req = 1'b1; step(); redetect_req = 1'b0;
        contact_edge();
        tick(5);
        pwr_good = 1'b0;
        step();
        chk("R10 drivers off on power loss", drv_bits(), 0);
        chk("R10 result cleared", {port_type, ilim_code, det_done}, 1 << 1);
        pwr_good = 1'b1;
        step();

        // constrained random
        for (int i = 0; i < 16; i++) begin
            bit use_contact = $urandom % 2;
            if (i > 0) begin
                if (i % 2 == 0) begin
                    redetect_req = 1'b1; step(); redetect_req = 1'b0;
                end else begin
                    pwr_good = 1'b0; step();
                    chk("R10 idle after power drop", {drv_bits(), det_done}, 0);
                    pwr_good = 1'b1; step();
                end
                chk("R1 contact drivers at start", drv_bits(), 4'b1100);
            end
            if (use_contact) begin
                contact_edge();
                run_primary(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            end else begin
                run_timeout(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule